// File: doc/BRIEF.md
# Relative Operand Address Normaliser

This block runs before an instruction executes in a machine whose memory is circular and addressed relative to the program counter. It takes the two operand fields of a fetched instruction, each with a two-bit addressing mode, together with the program counter. It turns each operand into one of two things: immediate data, or an absolute address in the range 0 to `CORE_SIZE`-1. The indirect modes need the B field of a memory cell, so the block reaches memory through one port that it uses for reads and writes. Reads return data one cycle after they are issued. In the predecrement mode the fetched value is decremented and written back before it is used.

The work is strictly ordered. The A operand is resolved completely, including any write-back, before the B operand issues any memory access. As a result, when both operands point at the same cell, B sees the value that A has already decremented. A `start` pulse in the idle state captures the inputs. `busy` stays high while operands are being resolved, and a one-cycle `done` strobe marks the moment `res_a` and `res_b` are valid.

The state machine has six states:
- `ST_IDLE` goes to `ST_A_RESOLVE` on `start`.
- `ST_A_RESOLVE` goes to `ST_A_FETCH` if the A mode is indirect or predecrement. Otherwise it goes to `ST_B_RESOLVE`.
- `ST_A_FETCH` goes to `ST_B_RESOLVE`.
- `ST_B_RESOLVE` goes to `ST_B_FETCH` for an indirect B, otherwise to `ST_DONE`.
- `ST_B_FETCH` goes to `ST_DONE`.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `operand_normaliser`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd` and `mem_wr` are 0, and `res_a`/`res_b` are 0.
- R2: Mode 2'b00 (immediate) returns the field value unchanged and makes no memory access for that operand.
- R3: Mode 2'b01 (direct) returns (pc + field) mod `CORE_SIZE` and makes no memory access for that operand.
- R4: Mode 2'b10 (indirect) reads the cell at (pc + field) mod `CORE_SIZE`. It returns (pc + read value) mod `CORE_SIZE` and writes nothing.
- R5: Mode 2'b11 (predecrement) reads the cell at (pc + field) mod `CORE_SIZE`. In the next cycle it writes (value − 1) back to the same address, with 0 wrapping to `CORE_SIZE`−1. It returns (pc + decremented value) mod `CORE_SIZE`.
- R6: Every memory access for A, including its write-back, happens before any access for B. A B read of a cell that A has decremented returns the decremented value.
- R7: Read data is taken on `mem_rdata` in the cycle after `mem_rd` is asserted.
- R8: `done` is a one-cycle pulse. It occurs 3 + (number of operands in mode 2'b10 or 2'b11) cycles after the clock edge that accepts `start`. `busy` is high in every cycle between that edge and `done`, and low while `done` is high.
- R9: `start` is accepted only in the idle state. A `start` while busy neither changes the results nor launches another operation.
- R10: `res_a` and `res_b` hold their values from `done` until the next accepted `start`, whatever the other inputs do.
- R11: `mem_rd` and `mem_wr` are never high together, and any accessed address is below `CORE_SIZE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin normalising the presented operands (idle only) |
| pc | input | AW | Program counter of the instruction |
| mode_a | input | 2 | A addressing mode: 00 imm, 01 direct, 10 indirect, 11 predecrement |
| field_a | input | AW | A operand field |
| mode_b | input | 2 | B addressing mode, same encoding |
| field_b | input | AW | B operand field |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request (predecrement write-back) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | AW | B-field value to write |
| mem_rdata | input | AW | B-field value read, valid one cycle after `mem_rd` |
| busy | output | 1 | Operands being resolved |
| done | output | 1 | One-cycle strobe: results valid |
| res_a | output | AW | Normalised A (data or absolute address) |
| res_b | output | AW | Normalised B (data or absolute address) |

## Verification
A state register that skips or repeats a step shows up at the ports within one operation. The `done` strobe arrives a cycle early or late against the 3-plus-indirect-count rule, and the read and write counts no longer match the modes. A wrong pointer or a missing decrement leaves the memory image and `res_a`/`res_b` wrong as soon as `done` fires. Ordering faults only appear when both operands hit the same cell, so the bench sweeps every mode pair against shared and separate cells, including a cell holding 0 so that the wrap is exercised.

// File: rtl/opnorm_pkg.sv
package opnorm_pkg;

    typedef enum logic [1:0] {
        MODE_IMM    = 2'b00,
        MODE_DIR    = 2'b01,
        MODE_IND    = 2'b10,
        MODE_PREDEC = 2'b11
    } addr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_A_RESOLVE,
        ST_A_FETCH,
        ST_B_RESOLVE,
        ST_B_FETCH,
        ST_DONE
    } norm_state_e;

    // Modes with bit 1 set need a memory fetch.
    function automatic logic needs_fetch(input addr_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/ring_add.sv
// Modular adder for operands already below SIZE.
module ring_add #(
    parameter int SIZE = 8000,
    parameter int AW   = $clog2(SIZE)
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic [AW-1:0] y
);
    localparam logic [AW:0] SIZE_W = (AW+1)'(SIZE);

    logic [AW:0] sum;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        y   = AW'((sum >= SIZE_W) ? (sum - SIZE_W) : sum);
    end
endmodule

// File: rtl/ring_dec.sv
// Modular decrement: 0 wraps to SIZE-1.
module ring_dec #(
    parameter int SIZE = 8000,
    parameter int AW   = $clog2(SIZE)
) (
    input  logic [AW-1:0] x,
    output logic [AW-1:0] y
);
    localparam logic [AW-1:0] TOP = AW'(SIZE - 1);

    always_comb begin
        y = (x == '0) ? TOP : (x - 1'b1);
    end
endmodule

// File: rtl/operand_normaliser.sv
module operand_normaliser
    import opnorm_pkg::*;
#(
    parameter int CORE_SIZE = 8000,
    parameter int AW        = $clog2(CORE_SIZE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] pc,
    input  logic [1:0]    mode_a,
    input  logic [AW-1:0] field_a,
    input  logic [1:0]    mode_b,
    input  logic [AW-1:0] field_b,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] res_a,
    output logic [AW-1:0] res_b
);

    norm_state_e   st_q, st_d;
    logic [AW-1:0] pc_q, fa_q, fb_q, ptr_q;
    addr_mode_e    ma_q, mb_q;
    logic [AW-1:0] res_a_q, res_b_q;

    // Operand currently in work, picked by state
    logic          on_b;
    addr_mode_e    cur_mode;
    logic [AW-1:0] cur_field;
    logic [AW-1:0] dir_addr, dec_val, fin_off, fin_addr;

    always_comb begin
        on_b      = (st_q == ST_B_RESOLVE) || (st_q == ST_B_FETCH);
        cur_mode  = on_b ? mb_q : ma_q;
        cur_field = on_b ? fb_q : fa_q;
        fin_off   = (cur_mode == MODE_PREDEC) ? dec_val : mem_rdata;
    end

    ring_add #(.SIZE(CORE_SIZE), .AW(AW)) u_dir_add (
        .a(pc_q), .b(cur_field), .y(dir_addr)
    );

    ring_dec #(.SIZE(CORE_SIZE), .AW(AW)) u_dec (
        .x(mem_rdata), .y(dec_val)
    );

    ring_add #(.SIZE(CORE_SIZE), .AW(AW)) u_fin_add (
        .a(pc_q), .b(fin_off), .y(fin_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state and outputs
    always_comb begin
        st_d      = st_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) st_d = ST_A_RESOLVE;
            end
            ST_A_RESOLVE, ST_B_RESOLVE: begin
                busy = 1'b1;
                if (needs_fetch(cur_mode)) begin
                    mem_rd   = 1'b1;
                    mem_addr = dir_addr;
                    st_d     = on_b ? ST_B_FETCH : ST_A_FETCH;
                end else begin
                    st_d     = on_b ? ST_DONE : ST_B_RESOLVE;
                end
            end
            ST_A_FETCH, ST_B_FETCH: begin
                busy = 1'b1;
                if (cur_mode == MODE_PREDEC) begin
                    mem_wr    = 1'b1;
                    mem_addr  = ptr_q;
                    mem_wdata = dec_val;
                end
                st_d = on_b ? ST_DONE : ST_B_RESOLVE;
            end
            ST_DONE: begin
                done = 1'b1;
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Operand datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            fa_q    <= '0;
            fb_q    <= '0;
            ma_q    <= MODE_IMM;
            mb_q    <= MODE_IMM;
            ptr_q   <= '0;
            res_a_q <= '0;
            res_b_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        pc_q <= pc;
                        fa_q <= field_a;
                        fb_q <= field_b;
                        ma_q <= addr_mode_e'(mode_a);
                        mb_q <= addr_mode_e'(mode_b);
                    end
                end
                ST_A_RESOLVE, ST_B_RESOLVE: begin
                    ptr_q <= dir_addr;
                    if (cur_mode == MODE_IMM) begin
                        if (on_b) res_b_q <= cur_field;
                        else      res_a_q <= cur_field;
                    end else if (cur_mode == MODE_DIR) begin
                        if (on_b) res_b_q <= dir_addr;
                        else      res_a_q <= dir_addr;
                    end
                end
                ST_A_FETCH: res_a_q <= fin_addr;
                ST_B_FETCH: res_b_q <= fin_addr;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign res_a = res_a_q;
    assign res_b = res_b_q;

    // Assertions
    assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_addr_in_core_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr < AW'(CORE_SIZE)));

    assert_writeback_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd) && (mem_addr == $past(mem_addr))));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> ($stable(res_a) && $stable(res_b)));

endmodule

// File: tb/test_operand_normaliser.sv
module test_operand_normaliser;

    localparam int S      = 11;
    localparam int AW     = $clog2(S);
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] pc = '0, field_a = '0, field_b = '0;
    logic [1:0]    mode_a = 2'b00, mode_b = 2'b00;
    logic          mem_rd, mem_wr, busy, done;
    logic [AW-1:0] mem_addr, mem_wdata, res_a, res_b;
    logic [AW-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] mem    [S];
    int            shadow [S];
    int            n_rd = 0, n_wr = 0;

    always #(CLK_NS/2) clk = ~clk;

    operand_normaliser #(.CORE_SIZE(S), .AW(AW)) i_operand_normaliser (
        .clk(clk), .rst_n(rst_n), .start(start), .pc(pc),
        .mode_a(mode_a), .field_a(field_a), .mode_b(mode_b), .field_b(field_b),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .res_a(res_a), .res_b(res_b)
    );

    // Memory model: read latency one cycle (R7)
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr];
            n_rd      <= n_rd + 1;
        end
        if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            n_wr          <= n_wr + 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Arithmetic reference for one operand, updates shadow memory
    task automatic model_op(input int m, input int f, input int p,
                            output int res, inout int nr, inout int nw);
        int a;
        a = (p + f) % S;
        case (m)
            0: res = f;
            1: res = a;
            2: begin res = (p + shadow[a]) % S; nr++; end
            default: begin
                shadow[a] = (shadow[a] + S - 1) % S;
                res = (p + shadow[a]) % S;
                nr++; nw++;
            end
        endcase
    endtask

    task automatic run_op(input int ma, input int fa, input int mb, input int fb,
                          input int p, input bit disturb);
        int ea, eb, nr, nw, cyc, busy_cnt, rd0, wr0, bad;
        for (int i = 0; i < S; i++) begin
            mem[i]    = AW'((i * 7 + 3) % S);
            shadow[i] = (i * 7 + 3) % S;
        end
        nr = 0; nw = 0;
        model_op(ma, fa, p, ea, nr, nw);   // A fully first (R6)
        model_op(mb, fb, p, eb, nr, nw);
        rd0 = n_rd; wr0 = n_wr;
        @(negedge clk);
        pc = AW'(p); mode_a = 2'(ma); field_a = AW'(fa);
        mode_b = 2'(mb); field_b = AW'(fb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            start = 1'b1; pc = AW'((p + 4) % S); field_a = AW'((fa + 2) % S);
            mode_a = 2'((ma + 1) % 4);
        end
        cyc = 1; busy_cnt = 0;
        while (!done && cyc < 40) begin
            if (busy) busy_cnt++;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        check("R8", "done latency", cyc, 3 + nr);
        check("R8", "busy cycles", busy_cnt, cyc - 1);
        check(ma == 0 ? "R2" : ma == 1 ? "R3" : ma == 2 ? "R4" : "R5", "res_a", int'(res_a), ea);
        check(mb == 0 ? "R2" : mb == 1 ? "R3" : mb == 2 ? "R4" : "R6", "res_b", int'(res_b), eb);
        check("R4", "read count", n_rd - rd0, nr);
        check("R5", "write count", n_wr - wr0, nw);
        bad = 0;
        for (int i = 0; i < S; i++) if (int'(mem[i]) != shadow[i]) bad++;
        check("R5", "memory image mismatches", bad, 0);
        @(negedge clk);
        check("R9", "busy after done", int'(busy), 0);
        check("R8", "done width", int'(done), 0);
        if (disturb) begin
            pc = AW'((p + 3) % S); field_b = AW'((fb + 5) % S);
            repeat (3) @(negedge clk);
            check("R10", "res_a held", int'(res_a), ea);
            check("R10", "res_b held", int'(res_b), eb);
            check("R9", "no relaunch", int'(busy), 0);
        end
    endtask

    initial begin
        int pcs [3] = '{0, 5, 10};
        int fas [3] = '{0, 6, 10};
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "mem access in reset", int'(mem_rd) + int'(mem_wr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "res_a after reset", int'(res_a), 0);
        check("R1", "res_b after reset", int'(res_b), 0);
        check("R1", "busy after reset", int'(busy), 0);
        for (int ma = 0; ma < 4; ma++)
            for (int mb = 0; mb < 4; mb++)
                for (int pi = 0; pi < 3; pi++)
                    for (int fi = 0; fi < 3; fi++)
                        for (int k = 0; k < 2; k++) begin
                            // k=0: both operands on the same cell (R6)
                            run_op(ma, fas[fi], mb, (k == 0) ? fas[fi] : (fas[fi] + 3) % S,
                                   pcs[pi], (k == 1) && (pi == fi));
                        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule